// File: doc/BRIEF.md
# I2C FIFO threshold event unit

This block holds the transmit and receive byte FIFOs that sit between the host and the serial engine of an I2C controller, and it produces the status events the host relies on to decide how many bytes to move at a time. The host fills the transmit FIFO and the serial engine empties it. The serial engine fills the receive FIFO and the host empties it. Each direction has its own programmable threshold.

Two kinds of event are produced in each direction. A "ready" event fires when a full threshold's worth of work is available. A "drain" event fires near the end of a transfer, when the bytes still outstanding can never make up a full threshold. In that case the host must move whatever remains instead of waiting. Status bits are sticky and cleared by writing ones. A mask selects which of them drive the single interrupt line.

The transfer direction and the count of bytes still outstanding come from the surrounding controller. In transmit, that count is the number of bytes the host has yet to supply. In receive, it is the number of bytes still to arrive from the bus.

Top module: `i2c_fifo_evt`

## Requirements
- R1: After reset both FIFO levels are 0, all status bits are 0 and the interrupt line is low.
- R2: Each FIFO delivers bytes in the order they were pushed. The read data always shows the oldest stored byte, and a pop advances to the next one.
- R3: A push into a full FIFO (8 << DEPTH_CODE bytes) and a pop from an empty FIFO are ignored. The level and the stored order are unchanged.
- R4: A flush input empties its FIFO at the next clock edge, and a push in the same cycle is discarded.
- R5: Each threshold input holds (threshold − 1). With the transmit direction selected, status bit 0 (transmit ready) is set when the TX level is below the TX threshold and the outstanding count is at least the TX threshold.
- R6: With the transmit direction selected, status bit 1 (transmit drain) is set when the TX level is below the TX threshold and the outstanding count is nonzero but below the TX threshold.
- R7: With the receive direction selected and a nonzero outstanding count, status bit 2 (receive ready) is set when the RX level is at or above the RX threshold. It is not set while the level is below the threshold.
- R8: With the receive direction selected, status bit 3 (receive drain) is set when the outstanding count is 0 and the RX FIFO is not empty. In this case receive ready is not set, even if the level reaches the threshold.
- R9: Writing 1 to a bit of the clear input clears that status bit at the next edge. If the bit's condition still holds in that cycle, the set wins and the bit stays 1.
- R10: The masked status equals the raw status ANDed with the enable mask, using the same bit order. The interrupt line is high exactly when any masked bit is 1.
- R11: The FIFO size field reads back the DEPTH_CODE parameter, meaning 8 << DEPTH_CODE bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tx_thr_m1 | input | THR_W | TX threshold minus one |
| rx_thr_m1 | input | THR_W | RX threshold minus one |
| dir_tx | input | 1 | 1 = transmit transfer, 0 = receive |
| xfer_left | input | CNT_W | Bytes still outstanding in the transfer |
| host_push | input | 1 | Host writes a byte into the TX FIFO |
| host_wdata | input | DW | Byte written by the host |
| eng_pop | input | 1 | Engine takes a byte from the TX FIFO |
| eng_rdata | output | DW | Oldest TX byte |
| eng_push | input | 1 | Engine writes a received byte |
| eng_wdata | input | DW | Received byte |
| host_pop | input | 1 | Host takes a byte from the RX FIFO |
| host_rdata | output | DW | Oldest RX byte |
| tx_flush | input | 1 | Empty the TX FIFO |
| rx_flush | input | 1 | Empty the RX FIFO |
| tx_level | output | AW+1 | TX FIFO fill |
| rx_level | output | AW+1 | RX FIFO fill |
| depth_code | output | 3 | FIFO size code n, size 8 << n |
| stat_w1c | input | 4 | Write-one-to-clear for status bits |
| irq_en | input | 4 | Interrupt enable mask |
| stat_raw | output | 4 | Status: [0] TX ready, [1] TX drain, [2] RX ready, [3] RX drain |
| stat_masked | output | 4 | Status ANDed with enable |
| irq | output | 1 | Combined interrupt |

## Verification
The properties assume that the outstanding count and the direction come from a controller that holds them steady around each event. They also assume the threshold fields do not change while a check window is open. Finally, they assume that a flush is never combined with a pop of the same FIFO on purpose. The stimulus changes the direction, count and thresholds only between phases, with the FIFOs idle. Pushes and pops are driven in separate cycles, so level expectations follow directly from the bench's queues.

// File: rtl/i2c_fifo_evt.sv
module i2c_fifo_evt #(
  parameter int DEPTH_CODE = 0,
  parameter int THR_W      = 6,
  parameter int CNT_W      = 16,
  parameter int DW         = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [THR_W-1:0] tx_thr_m1,
  input  logic [THR_W-1:0] rx_thr_m1,
  input  logic             dir_tx,
  input  logic [CNT_W-1:0] xfer_left,
  input  logic             host_push,
  input  logic [DW-1:0]    host_wdata,
  input  logic             eng_pop,
  output logic [DW-1:0]    eng_rdata,
  input  logic             eng_push,
  input  logic [DW-1:0]    eng_wdata,
  input  logic             host_pop,
  output logic [DW-1:0]    host_rdata,
  input  logic             tx_flush,
  input  logic             rx_flush,
  output logic [$clog2(8<<DEPTH_CODE):0] tx_level,
  output logic [$clog2(8<<DEPTH_CODE):0] rx_level,
  output logic [2:0]       depth_code,
  input  logic [3:0]       stat_w1c,
  input  logic [3:0]       irq_en,
  output logic [3:0]       stat_raw,
  output logic [3:0]       stat_masked,
  output logic             irq
);
  localparam int DEPTH = 8 << DEPTH_CODE;
  localparam int AW    = $clog2(DEPTH);
  localparam int LW    = AW + 1;

  logic [DW-1:0] tx_mem [DEPTH];
  logic [DW-1:0] rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [LW-1:0] tx_lvl, rx_lvl;
  logic tx_in, tx_out, rx_in, rx_out;

  assign tx_in  = host_push && !tx_flush && (tx_lvl != LW'(DEPTH));
  assign tx_out = eng_pop   && !tx_flush && (tx_lvl != '0);
  assign rx_in  = eng_push  && !rx_flush && (rx_lvl != LW'(DEPTH));
  assign rx_out = host_pop  && !rx_flush && (rx_lvl != '0);

  always_ff @(posedge clk) begin
    if (tx_in) tx_mem[tx_wp] <= host_wdata;
    if (rx_in) rx_mem[rx_wp] <= eng_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_lvl <= '0;
    end else if (tx_flush) begin
      tx_wp <= '0; tx_rp <= '0; tx_lvl <= '0;
    end else begin
      if (tx_in)  tx_wp <= tx_wp + 1'b1;
      if (tx_out) tx_rp <= tx_rp + 1'b1;
      tx_lvl <= tx_lvl + LW'(tx_in) - LW'(tx_out);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_lvl <= '0;
    end else if (rx_flush) begin
      rx_wp <= '0; rx_rp <= '0; rx_lvl <= '0;
    end else begin
      if (rx_in)  rx_wp <= rx_wp + 1'b1;
      if (rx_out) rx_rp <= rx_rp + 1'b1;
      rx_lvl <= rx_lvl + LW'(rx_in) - LW'(rx_out);
    end
  end

  assign eng_rdata  = tx_mem[tx_rp];
  assign host_rdata = rx_mem[rx_rp];
  assign tx_level   = tx_lvl;
  assign rx_level   = rx_lvl;
  assign depth_code = 3'(DEPTH_CODE);

  logic [31:0] tx_thr, rx_thr, left, tx_l, rx_l;
  assign tx_thr = 32'(tx_thr_m1) + 32'd1;
  assign rx_thr = 32'(rx_thr_m1) + 32'd1;
  assign left   = 32'(xfer_left);
  assign tx_l   = 32'(tx_lvl);
  assign rx_l   = 32'(rx_lvl);

  logic xdr_c, xrdy_c, rdr_c, rrdy_c;
  assign xdr_c  = dir_tx && (left != 0) && (left < tx_thr) && (tx_l < tx_thr);
  assign xrdy_c = dir_tx && (left >= tx_thr) && (tx_l < tx_thr);
  assign rdr_c  = !dir_tx && (left == 0) && (rx_l != 0);
  assign rrdy_c = !dir_tx && (left != 0) && (rx_l >= rx_thr);

  logic [3:0] stat;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= '0;
    else        stat <= (stat & ~stat_w1c) | {rdr_c, rrdy_c, xdr_c, xrdy_c};
  end

  assign stat_raw    = stat;
  assign stat_masked = stat & irq_en;
  assign irq         = |stat_masked;
endmodule

// File: rtl/i2c_fifo_evt_chk.sv
module i2c_fifo_evt_chk #(
  parameter int DEPTH = 8,
  parameter int THR_W = 6,
  parameter int CNT_W = 16,
  parameter int LW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dir_tx,
  input logic [CNT_W-1:0] xfer_left,
  input logic [THR_W-1:0] rx_thr_m1,
  input logic             host_push,
  input logic             eng_pop,
  input logic             eng_push,
  input logic             host_pop,
  input logic             tx_flush,
  input logic             rx_flush,
  input logic [LW-1:0]    tx_level,
  input logic [LW-1:0]    rx_level,
  input logic [3:0]       irq_en,
  input logic [3:0]       stat_raw,
  input logic             irq
);
  assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(tx_level) <= DEPTH) && (32'(rx_level) <= DEPTH));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(tx_level) == DEPTH && host_push && !eng_pop && !tx_flush) |=> (32'(tx_level) == DEPTH));

  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == '0 && host_pop && !eng_push && !rx_flush) |=> (rx_level == '0));

  assert_tx_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> (tx_level == '0));

  assert_rx_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> (rx_level == '0));

  assert_rx_ready_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_tx && xfer_left != '0 && 32'(rx_level) >= 32'(rx_thr_m1) + 32'd1) |=> stat_raw[2]);

  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == 4'b0) |-> !irq);
endmodule

bind i2c_fifo_evt i2c_fifo_evt_chk #(
  .DEPTH(8 << DEPTH_CODE), .THR_W(THR_W), .CNT_W(CNT_W), .LW($clog2(8 << DEPTH_CODE) + 1)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dir_tx(dir_tx), .xfer_left(xfer_left), .rx_thr_m1(rx_thr_m1),
  .host_push(host_push), .eng_pop(eng_pop), .eng_push(eng_push), .host_pop(host_pop),
  .tx_flush(tx_flush), .rx_flush(rx_flush), .tx_level(tx_level), .rx_level(rx_level),
  .irq_en(irq_en), .stat_raw(stat_raw), .irq(irq)
);

// File: tb/i2c_fifo_evt_tb.sv
module i2c_fifo_evt_tb;
  localparam int DEPTH = 8;

  logic clk = 0, rst_n = 0;
  logic [5:0] tx_thr_m1 = 6'd3, rx_thr_m1 = 6'd2;
  logic dir_tx = 1;
  logic [15:0] xfer_left = 0;
  logic host_push = 0, eng_pop = 0, eng_push = 0, host_pop = 0;
  logic [7:0] host_wdata = 0, eng_wdata = 0;
  logic [7:0] eng_rdata, host_rdata;
  logic tx_flush = 0, rx_flush = 0;
  logic [3:0] tx_level, rx_level;
  logic [2:0] depth_code;
  logic [3:0] stat_w1c = 0, irq_en = 0, stat_raw, stat_masked;
  logic irq;

  int checks = 0, fails = 0;
  logic [7:0] txq[$];
  logic [7:0] rxq[$];

  always #4 clk = ~clk;

  i2c_fifo_evt u_dut (
    .clk(clk), .rst_n(rst_n), .tx_thr_m1(tx_thr_m1), .rx_thr_m1(rx_thr_m1),
    .dir_tx(dir_tx), .xfer_left(xfer_left), .host_push(host_push), .host_wdata(host_wdata),
    .eng_pop(eng_pop), .eng_rdata(eng_rdata), .eng_push(eng_push), .eng_wdata(eng_wdata),
    .host_pop(host_pop), .host_rdata(host_rdata), .tx_flush(tx_flush), .rx_flush(rx_flush),
    .tx_level(tx_level), .rx_level(rx_level), .depth_code(depth_code),
    .stat_w1c(stat_w1c), .irq_en(irq_en), .stat_raw(stat_raw),
    .stat_masked(stat_masked), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic tx_write(input logic [7:0] b);
    if (txq.size() < DEPTH) txq.push_back(b);
    host_wdata = b; host_push = 1; step(); host_push = 0;
  endtask

  task automatic rx_write(input logic [7:0] b);
    if (rxq.size() < DEPTH) rxq.push_back(b);
    eng_wdata = b; eng_push = 1; step(); eng_push = 0;
  endtask

  task automatic clear_all();
    stat_w1c = 4'hF; step(); stat_w1c = 0;
  endtask

  // monitor: compares popped data against the scoreboard queues (R2, R3)
  always @(negedge clk) begin
    if (rst_n && eng_pop) begin
      chk("R3 tx level", 32'(tx_level), 32'(txq.size()));
      if (txq.size() > 0) chk("R2 tx order", 32'(eng_rdata), 32'(txq.pop_front()));
    end
    if (rst_n && host_pop) begin
      chk("R3 rx level", 32'(rx_level), 32'(rxq.size()));
      if (rxq.size() > 0) chk("R2 rx order", 32'(host_rdata), 32'(rxq.pop_front()));
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #2;
    rst_n = 1; step();
    chk("R1 tx_level", 32'(tx_level), 0);
    chk("R1 rx_level", 32'(rx_level), 0);
    chk("R1 stat", 32'(stat_raw), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R11 depth", 32'(depth_code), 0);

    // transmit ready with threshold 4
    xfer_left = 10; step();
    chk("R5 xrdy", 32'(stat_raw), 4'b0001);
    chk("R10 irq masked off", 32'(irq), 0);
    clear_all();
    chk("R9 set wins over clear", 32'(stat_raw), 4'b0001);
    for (int i = 0; i < 4; i++) tx_write(8'h10 + 8'(i));
    step(); clear_all();
    chk("R5 no xrdy at threshold", 32'(stat_raw), 0);
    for (int i = 4; i < 10; i++) tx_write(8'h10 + 8'(i));
    step();
    chk("R3 full holds", 32'(tx_level), DEPTH);
    eng_pop = 1; repeat (10) step(); eng_pop = 0;
    step();
    chk("R3 empty holds", 32'(tx_level), 0);

    // boundary: outstanding equals threshold -> ready only
    xfer_left = 4; clear_all();
    chk("R5 left equals thr", 32'(stat_raw), 4'b0001);
    xfer_left = 3; clear_all();
    chk("R6 xdr only", 32'(stat_raw), 4'b0010);
    irq_en = 4'b0010; step();
    chk("R10 masked", 32'(stat_masked), 4'b0010);
    chk("R10 irq", 32'(irq), 1);
    irq_en = 0;

    // flush with simultaneous push
    xfer_left = 0; clear_all();
    chk("R9 cleared", 32'(stat_raw), 0);
    tx_write(8'hA1); tx_write(8'hA2);
    host_wdata = 8'hA3; host_push = 1; tx_flush = 1; step();
    host_push = 0; tx_flush = 0; txq.delete();
    chk("R4 tx flush", 32'(tx_level), 0);

    // receive, threshold 3
    dir_tx = 0; xfer_left = 5; clear_all();
    rx_write(8'h51); rx_write(8'h52);
    step(); clear_all();
    chk("R7 no rrdy below thr", 32'(stat_raw), 0);
    rx_write(8'h53); step();
    chk("R7 rrdy", 32'(stat_raw), 4'b0100);
    irq_en = 4'b0100; step();
    chk("R10 irq rrdy", 32'(irq), 1);
    irq_en = 4'b1011; step();
    chk("R10 irq masked", 32'(irq), 0);

    // drain wins over ready
    xfer_left = 0; clear_all();
    chk("R8 rdr only", 32'(stat_raw), 4'b1000);
    chk("R10 irq rdr", 32'(irq), 1);
    host_pop = 1; repeat (4) step(); host_pop = 0;
    step();
    chk("R3 rx empty", 32'(rx_level), 0);
    clear_all();
    chk("R9 rdr cleared", 32'(stat_raw), 0);

    rx_write(8'h61); rx_write(8'h62);
    eng_wdata = 8'h63; eng_push = 1; rx_flush = 1; step();
    eng_push = 0; rx_flush = 0; rxq.delete();
    chk("R4 rx flush", 32'(rx_level), 0);
    rx_write(8'h71);
    host_pop = 1; step(); host_pop = 0; step();
    chk("R2 after flush", 32'(rx_level), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule